// File: doc/BRIEF.md
# Bit-Oriented Serial Frame Transmitter

This block takes bytes written into a small internal FIFO and sends them on one serial data line as bit-oriented frames. A frame is opened and closed by the flag byte 0x7E. Between the flags the payload bytes go out least significant bit first, followed by a 16-bit frame check sequence that the block computes itself. Software only supplies payload bytes. The flags and the check sequence are never written into the FIFO. One bit is sent for each cycle in which the external baud enable `baud_tick` is high.

While the transmitter is enabled and has nothing to send, it repeats flags on the line. The first byte that reaches the FIFO output starts a frame. When the FIFO runs dry in the middle of a frame, the `abort_mode` input selects the response. With `abort_mode` low, the frame ends normally: the check sequence goes out, then a flag. With `abort_mode` high, the frame is aborted: the line carries all-ones bytes, and a sticky interrupt is raised. A service request stays asserted while the FIFO holds half its depth or less.

The transmit FSM has five states. TX_OFF drives nothing, and enable moves it to TX_FLAG. TX_FLAG sends flags and moves to TX_DATA when a byte is available. TX_DATA sends payload bytes. An underrun in TX_DATA leads to TX_FCS in normal mode or to TX_ABORT in abort mode. TX_FCS sends two check bytes and then returns to TX_FLAG. TX_ABORT sends all-ones bytes until data arrives, then returns to TX_FLAG. Dropping enable returns every state to TX_OFF on the next clock.

Top module: `sdlc_tx`

## Requirements
- R1: After reset, or on the clock after `enable` is seen low, `tx_drive` is 0 and `txd` is 1. `svc_req`, `abort_irq` and `overflow` reset to 0.
- R2: While enabled with an empty FIFO, the line carries back-to-back flag bytes 0x7E, sent LSB first, with no inserted zeros.
- R3: Payload bytes are sent LSB first in FIFO order, one bit per `baud_tick`. After five consecutive ones in payload or check bytes, one extra 0 bit is inserted. `txd` changes only on a cycle with `baud_tick` high, unless `enable` is low.
- R4: The check sequence is the bit-reflected CRC-CCITT (polynomial 0x8408 in reflected form). It is preset to 0xFFFF and covers every payload byte of the frame. It is sent complemented, low byte first. A receiver running the same CRC over the payload and the check bits together ends on the residue 0xF0B8.
- R5: With `abort_mode` low, an underrun at the end of a payload byte sends the check sequence and then a closing flag. The line then idles on flags, and the next byte written starts a new frame.
- R6: With `abort_mode` high, an underrun at the end of a payload byte sends 0xFF bytes (runs of seven or more ones) until the FIFO holds data. One flag then follows, and then a new frame begins. `abort_irq` rises only after an underrun taken in abort mode.
- R7: `abort_irq` stays at 1 until a cycle with `irq_clr` high. If a new abort arrives in the same cycle as `irq_clr`, the abort wins.
- R8: `svc_req` is 1 exactly when `enable` is 1 and the FIFO holds at most DEPTH/2 bytes (4 of 8).
- R9: The FIFO holds DEPTH = 8 bytes. A write while it is full is dropped and sets `overflow`, which holds until `irq_clr`. Bytes written while the block is disabled are kept and are sent after enable.
- R10: When `enable` falls, the byte in progress stops at once. The shifter and FIFO are flushed, so the bytes that were queued are never sent. The next enable starts with a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Transmitter enable; a falling edge flushes |
| abort_mode | input | 1 | 1: an underrun aborts the frame; 0: an underrun closes it |
| baud_tick | input | 1 | Bit-rate enable, one bit per high cycle |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | FIFO write byte |
| irq_clr | input | 1 | Clears `abort_irq` and `overflow` |
| txd | output | 1 | Serial data out |
| tx_drive | output | 1 | 1 while the transmitter owns the line |
| svc_req | output | 1 | FIFO needs refilling |
| abort_irq | output | 1 | Sticky abort interrupt |
| overflow | output | 1 | Sticky FIFO overflow |

## Verification
The hardest situation to reach from the ports is a stuffed zero that falls on the last bit of a byte. The inserted bit must then go out before the following check byte or closing flag. The bench reaches it by sweeping frame lengths one to eight with byte patterns rich in 0xFF and 0x1F. A decoder in the bench removes stuffing from the raw line and checks the CRC residue, so any misplaced inserted bit shows up as a corrupt frame or a false abort. Reaching the abort path requires starting a frame in abort mode and letting the FIFO drain during it. Reaching the overflow path requires priming nine bytes while the block is disabled.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;

    typedef enum logic [2:0] {
        TX_OFF,
        TX_FLAG,
        TX_DATA,
        TX_FCS,
        TX_ABORT
    } tx_state_e;

    localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
    localparam logic [7:0]  ABORT_BYTE = 8'hFF;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;

    // Advance the reflected CRC over one byte, LSB first.
    function automatic logic [15:0] crc_byte(input logic [15:0] c_in, input logic [7:0] b);
        logic [15:0] c;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ b[i]) c = (c >> 1) ^ CRC_POLY_R;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdlc_tx_fifo.sv
module sdlc_tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          wr_ok, rd_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign wr_ok   = wr_en && !full && !flush;
    assign rd_ok   = rd_en && !empty && !flush;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (rd_ok) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            count <= count + CW'(wr_ok) - CW'(rd_ok);
        end
    end
endmodule

// File: rtl/sdlc_tx_crc.sv
module sdlc_tx_crc
    import sdlc_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        step,
    input  logic [7:0]  data_in,
    output logic [15:0] crc
);
    logic [15:0] crc_nx;

    assign crc_nx = crc_byte(start ? CRC_PRESET : crc, data_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc <= CRC_PRESET;
        else if (step) crc <= crc_nx;
    end
endmodule

// File: rtl/sdlc_tx.sv
module sdlc_tx
    import sdlc_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH) + 1,
    localparam int HALF = DEPTH / 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       abort_mode,
    input  logic       baud_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       irq_clr,
    output logic       txd,
    output logic       tx_drive,
    output logic       svc_req,
    output logic       abort_irq,
    output logic       overflow
);
    tx_state_e     state, state_nx;
    logic [7:0]    sh, sh_nx;
    logic [2:0]    bitcnt, bitcnt_nx;
    logic [2:0]    ones, ones_nx;
    logic          stuff, stuff_nx;
    logic          fcs_hi, fcs_hi_nx;
    logic          set_abort;
    logic          flush, fifo_rd, crc_start, crc_step;
    logic [7:0]    fifo_dout;
    logic [CW-1:0] fifo_cnt;
    logic          fifo_empty, fifo_full;
    logic [15:0]   crc;

    assign flush = (state != TX_OFF) && !enable;

    sdlc_tx_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(fifo_rd), .rd_data(fifo_dout),
        .count(fifo_cnt), .empty(fifo_empty), .full(fifo_full)
    );

    sdlc_tx_crc u_crc (
        .clk(clk), .rst_n(rst_n), .start(crc_start), .step(crc_step),
        .data_in(fifo_dout), .crc(crc)
    );

    // Next-state and datapath logic
    always_comb begin
        state_nx  = state;
        sh_nx     = sh;
        bitcnt_nx = bitcnt;
        ones_nx   = ones;
        stuff_nx  = stuff;
        fcs_hi_nx = fcs_hi;
        set_abort = 1'b0;
        fifo_rd   = 1'b0;
        crc_start = 1'b0;
        crc_step  = 1'b0;
        if (state == TX_OFF) begin
            if (enable) begin
                state_nx  = TX_FLAG;
                sh_nx     = FLAG_BYTE;
                bitcnt_nx = '0;
                ones_nx   = '0;
                stuff_nx  = 1'b0;
            end
        end else if (!enable) begin
            state_nx  = TX_OFF;
            sh_nx     = '0;
            bitcnt_nx = '0;
            ones_nx   = '0;
            stuff_nx  = 1'b0;
        end else if (baud_tick) begin
            if (stuff) begin
                stuff_nx = 1'b0;
                ones_nx  = '0;
            end else begin
                if ((state == TX_DATA || state == TX_FCS) && sh[0]) begin
                    if (ones == 3'd4) begin
                        ones_nx  = '0;
                        stuff_nx = 1'b1;
                    end else begin
                        ones_nx = ones + 1'b1;
                    end
                end else begin
                    ones_nx = '0;
                end
                if (bitcnt != 3'd7) begin
                    sh_nx     = {1'b0, sh[7:1]};
                    bitcnt_nx = bitcnt + 1'b1;
                end else begin
                    bitcnt_nx = '0;
                    unique case (state)
                        TX_FLAG: begin
                            if (!fifo_empty) begin
                                state_nx  = TX_DATA;
                                sh_nx     = fifo_dout;
                                fifo_rd   = 1'b1;
                                crc_step  = 1'b1;
                                crc_start = 1'b1;
                            end else begin
                                sh_nx = FLAG_BYTE;
                            end
                        end
                        TX_DATA: begin
                            if (!fifo_empty) begin
                                sh_nx    = fifo_dout;
                                fifo_rd  = 1'b1;
                                crc_step = 1'b1;
                            end else if (abort_mode) begin
                                state_nx  = TX_ABORT;
                                sh_nx     = ABORT_BYTE;
                                set_abort = 1'b1;
                            end else begin
                                state_nx  = TX_FCS;
                                sh_nx     = ~crc[7:0];
                                fcs_hi_nx = 1'b0;
                            end
                        end
                        TX_FCS: begin
                            if (!fcs_hi) begin
                                sh_nx     = ~crc[15:8];
                                fcs_hi_nx = 1'b1;
                            end else begin
                                state_nx = TX_FLAG;
                                sh_nx    = FLAG_BYTE;
                            end
                        end
                        TX_ABORT: begin
                            if (!fifo_empty) begin
                                state_nx = TX_FLAG;
                                sh_nx    = FLAG_BYTE;
                            end else begin
                                sh_nx = ABORT_BYTE;
                            end
                        end
                        TX_OFF: ;
                    endcase
                end
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= TX_OFF;
            sh        <= '0;
            bitcnt    <= '0;
            ones      <= '0;
            stuff     <= 1'b0;
            fcs_hi    <= 1'b0;
            abort_irq <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            state  <= state_nx;
            sh     <= sh_nx;
            bitcnt <= bitcnt_nx;
            ones   <= ones_nx;
            stuff  <= stuff_nx;
            fcs_hi <= fcs_hi_nx;
            if (set_abort)    abort_irq <= 1'b1;
            else if (irq_clr) abort_irq <= 1'b0;
            if (wr_en && fifo_full && !flush) overflow <= 1'b1;
            else if (irq_clr)                 overflow <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        tx_drive = (state != TX_OFF);
        txd      = (state == TX_OFF) ? 1'b1 : (!stuff && sh[0]);
        svc_req  = enable && (fifo_cnt <= CW'(HALF));
    end
endmodule

// File: rtl/sdlc_tx_chk.sv
module sdlc_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic abort_mode,
    input logic baud_tick,
    input logic irq_clr,
    input logic txd,
    input logic tx_drive,
    input logic abort_irq,
    input logic overflow
);
    // R1
    off_after_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !tx_drive);

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_drive |-> txd);

    // R3
    bit_per_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_drive && enable && !baud_tick) |=> $stable(txd));

    // R6
    abort_only_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_irq) |-> $past(abort_mode));

    // R7
    abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_irq && !irq_clr) |=> abort_irq);

    // R9
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !irq_clr) |=> overflow);
endmodule

bind sdlc_tx sdlc_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .abort_mode(abort_mode),
    .baud_tick(baud_tick), .irq_clr(irq_clr), .txd(txd), .tx_drive(tx_drive),
    .abort_irq(abort_irq), .overflow(overflow)
);

// File: tb/sim_sdlc_tx.sv
module sim_sdlc_tx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, abort_mode = 1'b0, baud_tick = 1'b0;
    logic wr_en = 1'b0, irq_clr = 1'b0;
    logic [7:0] wr_data = '0;
    logic txd, tx_drive, svc_req, abort_irq, overflow;

    always #5 clk = ~clk;

    sdlc_tx u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .abort_mode(abort_mode),
        .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data), .irq_clr(irq_clr),
        .txd(txd), .tx_drive(tx_drive), .svc_req(svc_req),
        .abort_irq(abort_irq), .overflow(overflow)
    );

    int total = 0, fails = 0, cycles = 0;

    // line decoder state
    logic bitbuf [256];
    int nbits = 0, ones = 0, frames = 0, aborts = 0, flags = 0, fr_len = 0;
    logic aborted = 1'b0, crc_good = 1'b0;
    logic [7:0] fr [16];
    logic [7:0] exp_b [16];

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic dec_reset();
        nbits = 0; ones = 0; aborted = 1'b0;
    endtask

    task automatic end_flag();
        int len;
        logic [15:0] c;
        flags++;
        len = (nbits >= 7) ? nbits - 7 : 0;
        if (aborted) aborts++;
        else if (len > 0) begin
            c = 16'hFFFF;
            for (int i = 0; i < len; i++) begin
                logic fb;
                fb = c[0] ^ bitbuf[i];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
            fr_len = len / 8;
            for (int k = 0; k < 16; k++) begin
                fr[k] = '0;
                for (int j = 0; j < 8; j++)
                    if (k*8 + j < len) fr[k][j] = bitbuf[k*8 + j];
            end
            crc_good = (c == 16'hF0B8) && (len % 8 == 0);
            frames++;
        end
        nbits = 0; ones = 0; aborted = 1'b0;
    endtask

    task automatic rx_bit(input logic b);
        if (b) begin
            ones++;
            if (ones >= 7) aborted = 1'b1;
            if (nbits < 256) bitbuf[nbits] = 1'b1;
            nbits++;
        end else if (ones >= 7) begin
            ones = 0; nbits = 0;
        end else if (ones == 6) begin
            end_flag();
        end else if (ones == 5) begin
            ones = 0;
        end else begin
            ones = 0;
            if (nbits < 256) bitbuf[nbits] = 1'b0;
            nbits++;
        end
    endtask

    // baud enable every third cycle; the bit seen is the one the next edge retires
    int tdiv = 0;
    always @(negedge clk) begin
        cycles++;
        if (tdiv == 2) begin
            tdiv <= 0;
            baud_tick <= 1'b1;
            if (rst_n && tx_drive) rx_bit(txd);
            else dec_reset();
        end else begin
            tdiv <= tdiv + 1;
            baud_tick <= 1'b0;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > 150000) begin
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        for (int t = 0; t < 4000 && frames < n; t++) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int len, input int i);
        logic [7:0] v;
        v = 8'(len * 37 + i * 53 + 8'h1F);
        if (i % 3 == 0) v = 8'hFF;
        if (i % 4 == 1) v = 8'h1F;
        return v;
    endfunction

    task automatic check_frame(input int n, input string req);
        int bad = 0;
        chk(fr_len == n + 2, req, fr_len, n + 2);
        chk(crc_good, "R4", int'(crc_good), 1);
        for (int i = 0; i < n; i++) if (fr[i] != exp_b[i]) bad++;
        chk(bad == 0, "R3", bad, 0);
    endtask

    initial begin
        int f0, a0, fl0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(txd == 1'b1 && tx_drive == 1'b0, "R1", int'({txd, tx_drive}), 2);
        chk(!svc_req && !abort_irq && !overflow, "R1", int'({svc_req, abort_irq, overflow}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        enable = 1'b1;
        repeat (300) @(negedge clk);
        // R2: flags only, empty FIFO requests service
        chk(flags >= 10 && frames == 0 && aborts == 0, "R2", flags, 10);
        chk(svc_req == 1'b1, "R8", int'(svc_req), 1);

        // R3 R4 R5: sweep frame lengths in normal mode
        for (int len = 1; len <= 8; len++) begin
            f0 = frames;
            for (int i = 0; i < len; i++) begin
                exp_b[i] = pat(len, i);
                push(exp_b[i]);
            end
            wait_frames(f0 + 1);
            chk(frames == f0 + 1, "R5", frames, f0 + 1);
            check_frame(len, "R5");
            fl0 = flags;
            repeat (120) @(negedge clk);
            chk(flags >= fl0 + 3 && frames == f0 + 1, "R5", flags - fl0, 3);
        end

        // R8 R9: prime while disabled, overflow on ninth byte
        enable = 1'b0;
        repeat (10) @(negedge clk);
        chk(svc_req == 1'b0, "R8", int'(svc_req), 0);
        for (int i = 0; i < 9; i++) begin
            exp_b[i] = 8'(8'hA0 + i * 9);
            push(exp_b[i]);
        end
        chk(overflow == 1'b1, "R9", int'(overflow), 1);
        f0 = frames;
        enable = 1'b1;
        @(negedge clk);
        chk(svc_req == 1'b0, "R8", int'(svc_req), 0);
        wait_frames(f0 + 1);
        check_frame(8, "R9");
        chk(svc_req == 1'b1 && overflow == 1'b1, "R9", int'({svc_req, overflow}), 3);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        chk(overflow == 1'b0, "R9", int'(overflow), 0);

        // R6 R7: abort on underrun
        abort_mode = 1'b1;
        a0 = aborts; f0 = frames;
        for (int i = 0; i < 3; i++) push(8'h55);
        for (int t = 0; t < 2000 && !abort_irq; t++) @(negedge clk);
        chk(abort_irq == 1'b1, "R6", int'(abort_irq), 1);
        repeat (60) @(negedge clk);
        chk(ones >= 7, "R6", ones, 7);
        abort_mode = 1'b0;
        exp_b[0] = 8'h3C; exp_b[1] = 8'hFE;
        push(exp_b[0]); push(exp_b[1]);
        wait_frames(f0 + 1);
        chk(aborts == a0 + 1, "R6", aborts, a0 + 1);
        check_frame(2, "R6");
        chk(abort_irq == 1'b1, "R7", int'(abort_irq), 1);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        chk(abort_irq == 1'b0, "R7", int'(abort_irq), 0);

        // R10: disable mid-frame flushes everything
        f0 = frames;
        for (int i = 0; i < 6; i++) push(8'h81);
        repeat (60) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(tx_drive == 1'b0 && txd == 1'b1, "R10", int'({tx_drive, txd}), 1);
        repeat (10) @(negedge clk);
        fl0 = flags;
        enable = 1'b1;
        repeat (400) @(negedge clk);
        chk(frames == f0 && svc_req == 1'b1, "R10", frames, f0);
        chk(flags >= fl0 + 10, "R10", flags - fl0, 10);
        summary();
    end
endmodule